// File: doc/BRIEF.md
# Frame-Synchronized Display Configuration Register

This block is one 32-bit configuration word for a display pipeline, reached over a simple register bus. Software writes land in a pending copy, which is what software reads back. The display logic sees a separate applied copy. The applied copy takes the pending value only when a frame-start strobe arrives, so a frame is never shown with half-updated settings. The frame-start strobe marks either a frame or an interlaced field boundary.

The one exception is the interrupt-source select bit. It passes to the applied outputs on the cycle after it is written. The block also makes a vertical interrupt pulse. The select bit picks which timing strobe raises the pulse: start of vertical blank or end of vertical sync. The applied enable bit gates the pulse. A border-qualify bit decides whether the display-enable output covers only the active region or the border as well. The vertical timing, the pixel path and the colour lookup live elsewhere and reach this block only as strobes and region flags.

Top module: `dcfg_reg`

## Requirements
- R1: After reset, the readback, the applied configuration, the interrupt pulse and the display enable are all zero.
- R2: A bus write with `bus_addr` equal to 0x08 stores the data in the pending copy. From the cycle after the write, `bus_rdata` returns that value while the address is 0x08, even though the data has not yet been applied.
- R3: Bits 31:28, bit 26 and bits 23:20 are reserved. They always read as zero and always appear as zero on `cfg_active`.
- R4: On the clock edge where `frame_start` is high, `cfg_active` takes the pending value. It is visible from the next cycle.
- R5: Bit 27, the interrupt-source select, reaches `cfg_active` on the cycle after it is written, with no frame start needed.
- R6: A write made between frame starts leaves every `cfg_active` bit other than bit 27 unchanged until the next `frame_start`.
- R7: With applied bit 5 (interrupt enable) at 1 and bit 27 at 0, `vblank_start` makes `vint_pulse` high for one cycle, one cycle later. `vsync_end` raises no pulse.
- R8: With applied bit 5 at 1 and bit 27 at 1, `vsync_end` makes `vint_pulse` high for one cycle, one cycle later. `vblank_start` raises no pulse.
- R9: With applied bit 5 at 0, neither strobe raises `vint_pulse`.
- R10: `vint_pulse` is registered and lasts exactly one cycle, even when the selected strobe stays high for several cycles.
- R11: When applied bit 24 is 0, `disp_en` follows `in_active`. When it is 1, `disp_en` is `in_active` OR `in_border`.
- R12: A write to any address other than 0x08 leaves the stored value unchanged, and a read at any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (pending copy at the matching address) |
| frame_start | input | 1 | Frame or field boundary strobe |
| vblank_start | input | 1 | Start of vertical blank strobe |
| vsync_end | input | 1 | End of vertical sync strobe |
| in_active | input | 1 | Current pixel lies in the active region |
| in_border | input | 1 | Current pixel lies in the border region |
| disp_en | output | 1 | Display-enable qualifier |
| cfg_active | output | 32 | Applied configuration driving the display logic |
| vint_pulse | output | 1 | One-cycle vertical interrupt pulse |

## Verification
A table of write words is applied one at a time: all ones, all zeros, two alternating checkerboards, and a word with only the select and enable bits set. For each word the bench reads it back, checks `cfg_active` before the frame strobe and checks it again after. This separates the masking of reserved bits, the late apply of ordinary bits and the early apply of bit 27. Each timing strobe is then fired under both select values and with the enable on and off, which shows whether the wrong event is being routed or the gate is missing. A held strobe shows whether the pulse is edge-shaped. Mid-frame writes, writes to other addresses and the border flag are driven in directed steps.

// File: rtl/dcfg_pkg.sv
package dcfg_pkg;
   localparam int unsigned DCFG_W        = 32;
   localparam logic [31:0] DCFG_RSVD     = 32'hF4F0_0000;
   localparam int unsigned DCFG_SEL_BIT  = 27;
   localparam int unsigned DCFG_CTR_BIT  = 24;
   localparam int unsigned DCFG_IEN_BIT  = 5;

   typedef enum logic {
      VINT_AT_VBLANK    = 1'b0,
      VINT_AT_VSYNC_END = 1'b1
   } vint_src_e;
endpackage

// File: rtl/dcfg_host_port.sv
module dcfg_host_port #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h08,
   parameter logic [DATA_W-1:0] RSVD_MASK  = 32'hF4F0_0000,
   parameter bit          RDATA_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [DATA_W-1:0] pend_q,
   output logic              wr_hit
);
   localparam logic [DATA_W-1:0] WR_MASK = ~RSVD_MASK;

   logic addr_hit;
   assign addr_hit = (bus_addr == REG_OFFSET);
   assign wr_hit   = bus_wr && addr_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_q <= '0;
      else if (wr_hit) pend_q <= bus_wdata & WR_MASK;
   end

   logic [DATA_W-1:0] rd_mux;
   assign rd_mux = addr_hit ? pend_q : '0;

   generate
      if (RDATA_REG) begin : g_rd_reg
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= rd_mux;
         end
         assign bus_rdata = rd_q;
      end else begin : g_rd_comb
         assign bus_rdata = rd_mux;
      end
   endgenerate

   // R12: a write elsewhere leaves the stored word alone
   a_r12_foreign_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !addr_hit) |=> $stable(pend_q));
   // R2: a matching write is captured with reserved bits cleared
   a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> pend_q == ($past(bus_wdata) & WR_MASK));
endmodule

// File: rtl/dcfg_frame_shadow.sv
module dcfg_frame_shadow #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned IMM_BIT = 27
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic [DATA_W-1:0] pend_i,
   output logic [DATA_W-1:0] active_o
);
   logic [DATA_W-1:0] shadow_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           shadow_q <= '0;
      else if (frame_start) shadow_q <= pend_i;
   end

   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         if (b == IMM_BIT) begin : g_imm
            assign active_o[b] = pend_i[b];
         end else begin : g_sync
            assign active_o[b] = shadow_q[b];
         end
      end
   endgenerate

   // R6: applied copy holds between frame boundaries
   a_r6_hold_mid_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(shadow_q));
   // R4: a boundary loads the pending word
   a_r4_apply: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> shadow_q == $past(pend_i));
endmodule

// File: rtl/dcfg_vint.sv
module dcfg_vint
   import dcfg_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic src_sel,
   input  logic irq_en,
   input  logic vblank_start,
   input  logic vsync_end,
   output logic irq_o
);
   vint_src_e src;
   logic      evt, evt_d, irq_q;

   assign src = vint_src_e'(src_sel);
   always_comb begin
      unique case (src)
         VINT_AT_VBLANK:    evt = irq_en && vblank_start;
         VINT_AT_VSYNC_END: evt = irq_en && vsync_end;
         default:           evt = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_d <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         evt_d <= evt;
         irq_q <= evt && !evt_d;
      end
   end
   assign irq_o = irq_q;

   // R10: never two pulse cycles in a row
   a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);
   // R9: no pulse without enable
   a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |=> !irq_o);
   // R7 / R8: pulse traces back to the selected strobe
   a_r8_source: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ($past(src_sel) ? $past(vsync_end) : $past(vblank_start)));
endmodule

// File: rtl/dcfg_reg.sv
module dcfg_reg
   import dcfg_pkg::*;
#(
   parameter int unsigned DATA_W     = DCFG_W,
   parameter int unsigned ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h08,
   parameter logic [DATA_W-1:0] RSVD_MASK  = DCFG_RSVD,
   parameter int unsigned SEL_BIT    = DCFG_SEL_BIT,
   parameter int unsigned CTR_BIT    = DCFG_CTR_BIT,
   parameter int unsigned IEN_BIT    = DCFG_IEN_BIT,
   parameter bit          RDATA_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              frame_start,
   input  logic              vblank_start,
   input  logic              vsync_end,
   input  logic              in_active,
   input  logic              in_border,
   output logic              disp_en,
   output logic [DATA_W-1:0] cfg_active,
   output logic              vint_pulse
);
   generate
      if (SEL_BIT >= DATA_W || CTR_BIT >= DATA_W || IEN_BIT >= DATA_W) begin : g_bad_bit
         $error("dcfg_reg: control bit index outside the word");
      end
      if (RSVD_MASK[SEL_BIT] || RSVD_MASK[CTR_BIT] || RSVD_MASK[IEN_BIT]) begin : g_bad_mask
         $error("dcfg_reg: a control bit is marked reserved");
      end
      if (SEL_BIT == CTR_BIT || SEL_BIT == IEN_BIT || CTR_BIT == IEN_BIT) begin : g_bad_dup
         $error("dcfg_reg: control bits overlap");
      end
   endgenerate

   logic [DATA_W-1:0] pend_q;
   logic              wr_hit;

   dcfg_host_port #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET),
      .RSVD_MASK(RSVD_MASK), .RDATA_REG(RDATA_REG)
   ) u_host (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pend_q(pend_q),
      .wr_hit(wr_hit)
   );

   dcfg_frame_shadow #(.DATA_W(DATA_W), .IMM_BIT(SEL_BIT)) u_shadow (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .pend_i(pend_q), .active_o(cfg_active)
   );

   dcfg_vint u_vint (
      .clk(clk), .rst_n(rst_n), .src_sel(cfg_active[SEL_BIT]),
      .irq_en(cfg_active[IEN_BIT]), .vblank_start(vblank_start),
      .vsync_end(vsync_end), .irq_o(vint_pulse)
   );

   assign disp_en = in_active || (cfg_active[CTR_BIT] && in_border);

   // R3: reserved positions never reach the display logic
   a_r3_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_active & RSVD_MASK) == '0);
   // R5: select bit follows a write on the next cycle
   a_r5_sel_immediate: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == REG_OFFSET) |=> cfg_active[SEL_BIT] == $past(bus_wdata[SEL_BIT]));
   // R11: with border qualify off, enable tracks the active flag only
   a_r11_active_only: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_active[CTR_BIT] |-> disp_en == in_active);
endmodule

// File: tb/dcfg_reg_tb.sv
module dcfg_reg_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = 8'h08;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        frame_start = 1'b0, vblank_start = 1'b0, vsync_end = 1'b0;
   logic        in_active = 1'b0, in_border = 1'b0;
   logic        disp_en, vint_pulse;
   logic [31:0] cfg_active;

   int n_chk = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   dcfg_reg u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_start(frame_start),
      .vblank_start(vblank_start), .vsync_end(vsync_end), .in_active(in_active),
      .in_border(in_border), .disp_en(disp_en), .cfg_active(cfg_active),
      .vint_pulse(vint_pulse)
   );

   localparam logic [31:0] SEL = 32'h0800_0000;
   // {write word, expected readback}
   localparam logic [63:0] VEC [5] = '{
      {32'hFFFF_FFFF, 32'h0B0F_FFFF},
      {32'h0000_0000, 32'h0000_0000},
      {32'hA5A5_A5A5, 32'h0105_A5A5},
      {32'h0800_0020, 32'h0800_0020},
      {32'h5A5A_5A5A, 32'h0A0A_5A5A}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0; bus_addr = 8'h08;
      #1;
   endtask

   task automatic frame();
      @(negedge clk); frame_start = 1'b1;
      @(negedge clk); frame_start = 1'b0;
      #1;
   endtask

   // fire one strobe for one cycle; check pulse in the two following cycles
   task automatic strobe(input bit vs, input logic exp, input string req);
      @(negedge clk); if (vs) vsync_end = 1'b1; else vblank_start = 1'b1;
      @(negedge clk); vsync_end = 1'b0; vblank_start = 1'b0;
      #1; chk(req, {31'b0, vint_pulse}, {31'b0, exp});
      @(negedge clk); #1; chk(req, {31'b0, vint_pulse}, 32'h0);
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] prev;
      repeat (3) @(negedge clk);
      #1;
      chk("R1 rdata", bus_rdata, 32'h0);
      chk("R1 active", cfg_active, 32'h0);
      chk("R1 irq", {31'b0, vint_pulse}, 32'h0);
      chk("R1 disp_en", {31'b0, disp_en}, 32'h0);
      rst_n = 1'b1;

      prev = '0;
      for (int i = 0; i < 5; i++) begin
         logic [31:0] w, e;
         {w, e} = VEC[i];
         wr(8'h08, w);
         chk("R2 R3 readback", bus_rdata, e);
         chk("R5 R6 before frame", cfg_active, (prev & ~SEL) | (e & SEL));
         frame();
         chk("R4 R3 after frame", cfg_active, e);
         prev = e;
      end

      // R12: foreign address
      wr(8'h0C, 32'hFFFF_FFFF);
      chk("R12 stored unchanged", bus_rdata, 32'h0A0A_5A5A);
      bus_addr = 8'h0C; #1;
      chk("R12 foreign read", bus_rdata, 32'h0);
      bus_addr = 8'h08; #1;

      // R6: two writes in one frame
      wr(8'h08, 32'h0000_1234); frame();
      wr(8'h08, 32'h0000_4321);
      frame_start = 1'b0;
      repeat (3) @(negedge clk);
      #1; chk("R6 held mid-frame", cfg_active, 32'h0000_1234);
      frame();
      chk("R6 applied next frame", cfg_active, 32'h0000_4321);

      // R7: vblank source
      wr(8'h08, 32'h0000_0020); frame();
      strobe(1'b0, 1'b1, "R7 vblank fires");
      strobe(1'b1, 1'b0, "R7 vsync_end ignored");
      // R8: select applies without frame start
      wr(8'h08, 32'h0800_0020);
      strobe(1'b1, 1'b1, "R8 vsync_end fires");
      strobe(1'b0, 1'b0, "R8 vblank ignored");
      // R10: held strobe
      @(negedge clk); vsync_end = 1'b1;
      @(negedge clk); #1; chk("R10 first cycle", {31'b0, vint_pulse}, 32'h1);
      @(negedge clk); #1; chk("R10 held strobe", {31'b0, vint_pulse}, 32'h0);
      @(negedge clk); #1; chk("R10 still held", {31'b0, vint_pulse}, 32'h0);
      vsync_end = 1'b0;
      // R9: disabled
      wr(8'h08, 32'h0800_0000); frame();
      strobe(1'b1, 1'b0, "R9 disabled vsync_end");
      wr(8'h08, 32'h0000_0000); frame();
      strobe(1'b0, 1'b0, "R9 disabled vblank");

      // R11: border qualify
      in_active = 1'b0; in_border = 1'b1; #1;
      chk("R11 border off", {31'b0, disp_en}, 32'h0);
      wr(8'h08, 32'h0100_0000);
      chk("R11 not yet applied", {31'b0, disp_en}, 32'h0);
      frame();
      chk("R11 border on", {31'b0, disp_en}, 32'h1);
      in_border = 1'b0; #1;
      chk("R11 neither region", {31'b0, disp_en}, 32'h0);
      wr(8'h08, 32'h0); frame();
      in_active = 1'b1; #1;
      chk("R11 active only", {31'b0, disp_en}, 32'h1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule